// File: doc/BRIEF.md
# Six-Phase Instruction Cycle Sequencer

This block is the control unit of a small 16-bit processor built around a register file. Every instruction goes through one fixed sequence of phases: fetch, decode, address evaluation, operand fetch, execute and result store. Decode picks which of these phases an instruction skips. The block holds the program counter and the memory address, memory data and instruction registers. It drives their load enables and runs a request/ready handshake with an external memory. The arithmetic and the register file sit outside the block. From this block they get a one-cycle execute pulse, a one-cycle register write pulse, and the memory data register as their operand.

A run bit gates every phase step. Reset sets the run bit, loads the program counter from a vector input and puts the machine in fetch. A halt opcode clears the run bit. A halt request clears it at the next instruction boundary. A start pulse sets it again, and execution carries on from the held program counter.

Instruction word layout: bits [15:12] hold the opcode. Bits [8:0] hold a signed word offset. The effective address is the already-incremented program counter plus the sign-extended offset.

Top module: `icyc_seq`

## Requirements
- R1: While reset is high, `pc_out` equals `reset_vec`, `running` is 1, `phase` is fetch (code 0) and `mem_req` is low.
- R2: Fetch places the program counter on `mem_addr` for the first request of the instruction. It increments the program counter by one and loads the returned word into `ir_out`.
- R3: Phase codes are fetch 0, decode 1, address 2, operand 3, execute 4, store 5. Within an instruction the code only rises. It returns to 0 only when the instruction ends.
- R4: `mem_req` is a one-cycle pulse. After a request the sequencer holds its phase until `mem_ready` is high and issues no other request in the meantime.
- R5: Opcode 1 (operate) visits fetch, decode, execute and store only. It raises `reg_we` once, in the store phase.
- R6: Opcode 2 (load) visits all six phases and reads the effective address. When `reg_we` pulses, `mem_wdata` carries the word read.
- R7: Opcode 3 (store) skips operand fetch. In the store phase it writes `st_data` to the effective address, with `mem_we` high together with `mem_req`.
- R8: Opcode 4 (jump) loads the effective address into the program counter and skips both the operand and the store phases.
- R9: Opcode 15 (halt) skips the address, operand and store phases. It clears `running`, and no request, write pulse or execute pulse follows while halted.
- R10: A one-cycle `halt_req` pulse lets the current instruction complete. It then clears `running` before the next fetch request.
- R11: A `start` pulse while halted sets `running` again. The next fetch reads from the held program counter.
- R12: Any other opcode visits fetch, decode, execute and store, with no `reg_we`, no `alu_en` and no memory write.
- R13: `alu_en` is a one-cycle pulse in the execute phase, and only for opcode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 16 | Program counter value loaded at reset |
| start | input | 1 | Sets the run bit while halted |
| halt_req | input | 1 | Requests a halt at the next instruction boundary |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_we | output | 1 | Write qualifier for `mem_req` |
| mem_addr | output | 16 | Memory address register |
| mem_wdata | output | 16 | Memory data register |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completion pulse |
| st_data | input | 16 | Register-file value for store instructions |
| ir_out | output | 16 | Instruction register |
| pc_out | output | 16 | Program counter |
| phase | output | 3 | Current phase code |
| running | output | 1 | Run bit |
| alu_en | output | 1 | Execute pulse for operate instructions |
| reg_we | output | 1 | Register-file write pulse |

## Verification
The assertions take for granted that the memory answers every request with exactly one `mem_ready` pulse, no earlier than the cycle after the request. They also assume `mem_ready` is never raised while no request is outstanding. The bench memory model keeps to this. It latches each request, counts out a per-test latency of one to three cycles, and then pulses ready once. Between tests the bench holds reset long enough for any reply still in flight to drain before the next program is loaded.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_OPR   = 4'h1;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h2;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'h4;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [3:0] {
    ST_FA, ST_FR, ST_FW, ST_FI, ST_DEC, ST_EVAL,
    ST_OR, ST_OW, ST_EXEC, ST_STR, ST_SW
  } st_t;

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0, PH_DECODE = 3'd1, PH_EVAL = 3'd2,
    PH_OPND = 3'd3, PH_EXEC = 3'd4, PH_STORE = 3'd5
  } ph_t;

  typedef enum logic [2:0] {
    K_OPR, K_LOAD, K_STORE, K_JUMP, K_HALT, K_NOP
  } kind_t;

  typedef struct packed {
    kind_t kind;
    logic  need_ea;
    logic  need_opnd;
    logic  need_store;
  } dec_t;

  typedef struct packed {
    logic mar_pc;
    logic mar_ea;
    logic mdr_mem;
    logic mdr_st;
    logic ir_ld;
    logic pc_inc;
    logic pc_ea;
  } ld_t;
endpackage

// File: rtl/icyc_decode.sv
module icyc_decode
  import icyc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  always_comb begin
    dec = '{kind: K_NOP, need_ea: 1'b0, need_opnd: 1'b0, need_store: 1'b1};
    case (opcode)
      OP_OPR:   dec.kind = K_OPR;
      OP_LOAD:  begin dec.kind = K_LOAD;  dec.need_ea = 1'b1; dec.need_opnd = 1'b1; end
      OP_STORE: begin dec.kind = K_STORE; dec.need_ea = 1'b1; end
      OP_JUMP:  begin dec.kind = K_JUMP;  dec.need_ea = 1'b1; dec.need_store = 1'b0; end
      OP_HALT:  begin dec.kind = K_HALT;  dec.need_store = 1'b0; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
  import icyc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int EW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vec,
  input  ld_t           ld,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] st_data,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] pc
);
  localparam int XW = AW - EW;

  logic [AW-1:0] ea;
  assign ea = pc + {{XW{ir[EW-1]}}, ir[EW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= reset_vec;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (ld.pc_inc)       pc <= pc + AW'(1);
      else if (ld.pc_ea)   pc <= mar;
      if (ld.mar_pc)       mar <= pc;
      else if (ld.mar_ea)  mar <= ea;
      if (ld.mdr_mem)      mdr <= mem_rdata;
      else if (ld.mdr_st)  mdr <= st_data;
      if (ld.ir_ld)        ir <= mdr;
    end
  end

  // R2: fetch steps the program counter by exactly one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ($past(ld.pc_inc) && !$past(rst)) |-> (pc == $past(pc) + AW'(1)));
  // R8: a jump takes the address register into the program counter
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    ($past(ld.pc_ea) && !$past(rst)) |-> (pc == $past(mar)));
  a_r2_ld_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld.mar_pc, ld.mar_ea, ld.mdr_mem, ld.mdr_st, ld.ir_ld, ld.pc_ea}));
endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       halt_req,
  input  logic       mem_ready,
  input  dec_t       dec,
  output ld_t        ld,
  output logic       mem_req,
  output logic       mem_we,
  output logic       alu_en,
  output logic       reg_we,
  output logic [2:0] phase,
  output logic       running
);
  st_t  state, nxt;
  logic run, halt_pend, stop_now, halt_op;

  assign stop_now = (state == ST_FA) && run && (halt_pend || halt_req);
  assign halt_op  = (state == ST_EXEC) && (dec.kind == K_HALT);

  always_comb begin
    nxt     = state;
    ld      = '0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    alu_en  = 1'b0;
    reg_we  = 1'b0;
    case (state)
      ST_FA: if (run && !stop_now) begin
        ld.mar_pc = 1'b1;
        ld.pc_inc = 1'b1;
        nxt       = ST_FR;
      end
      ST_FR: begin mem_req = 1'b1; nxt = ST_FW; end
      ST_FW: if (mem_ready) begin ld.mdr_mem = 1'b1; nxt = ST_FI; end
      ST_FI: begin ld.ir_ld = 1'b1; nxt = ST_DEC; end
      ST_DEC: nxt = dec.need_ea ? ST_EVAL : ST_EXEC;
      ST_EVAL: begin
        ld.mar_ea = 1'b1;
        nxt       = dec.need_opnd ? ST_OR : ST_EXEC;
      end
      ST_OR: begin mem_req = 1'b1; nxt = ST_OW; end
      ST_OW: if (mem_ready) begin ld.mdr_mem = 1'b1; nxt = ST_EXEC; end
      ST_EXEC: begin
        case (dec.kind)
          K_OPR:   alu_en    = 1'b1;
          K_STORE: ld.mdr_st = 1'b1;
          K_JUMP:  ld.pc_ea  = 1'b1;
          default: ;
        endcase
        nxt = dec.need_store ? ST_STR : ST_FA;
      end
      ST_STR: begin
        if (dec.kind == K_STORE) begin
          mem_req = 1'b1;
          mem_we  = 1'b1;
          nxt     = ST_SW;
        end else begin
          reg_we = (dec.kind == K_OPR) || (dec.kind == K_LOAD);
          nxt    = ST_FA;
        end
      end
      ST_SW: if (mem_ready) nxt = ST_FA;
      default: nxt = ST_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FA;
      run       <= 1'b1;
      halt_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (halt_op || stop_now) begin
        run       <= 1'b0;
        halt_pend <= 1'b0;
      end else if (!run) begin
        if (start && !halt_req) run <= 1'b1;
      end else if (halt_req) begin
        halt_pend <= 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_DEC:          phase = PH_DECODE;
      ST_EVAL:         phase = PH_EVAL;
      ST_OR, ST_OW:    phase = PH_OPND;
      ST_EXEC:         phase = PH_EXEC;
      ST_STR, ST_SW:   phase = PH_STORE;
      default:         phase = PH_FETCH;
    endcase
  end
  assign running = run;

  // R4: request is a single-cycle strobe
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R4: a wait phase holds until memory answers
  a_r4_wait_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_FW || state == ST_OW || state == ST_SW) && !mem_ready) |=> (state == $past(state)));
  // R3: phases only rise inside an instruction
  a_r3_phase_order: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == PH_FETCH || phase > $past(phase)));
  // R9: nothing is issued while halted
  a_r9_halted_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!mem_req && !reg_we && !alu_en));
  // R13: execute pulse only in the execute phase
  a_r13_alu_phase: assert property (@(posedge clk) disable iff (rst)
    alu_en |-> (phase == PH_EXEC));
  // R7: write qualifier never without a request
  a_r7_we_with_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int EW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vec,
  input  logic          start,
  input  logic          halt_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] st_data,
  output logic [DW-1:0] ir_out,
  output logic [AW-1:0] pc_out,
  output logic [2:0]    phase,
  output logic          running,
  output logic          alu_en,
  output logic          reg_we
);
  localparam int OPLO = DW - OPC_W;

  dec_t dec;
  ld_t  ld;
  logic [DW-1:0] ir;

  icyc_decode u_dec (
    .opcode (ir[DW-1:OPLO]),
    .dec    (dec)
  );

  icyc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .halt_req  (halt_req),
    .mem_ready (mem_ready),
    .dec       (dec),
    .ld        (ld),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .alu_en    (alu_en),
    .reg_we    (reg_we),
    .phase     (phase),
    .running   (running)
  );

  icyc_regs #(.AW(AW), .DW(DW), .EW(EW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reset_vec (reset_vec),
    .ld        (ld),
    .mem_rdata (mem_rdata),
    .st_data   (st_data),
    .mar       (mem_addr),
    .mdr       (mem_wdata),
    .ir        (ir),
    .pc        (pc_out)
  );

  assign ir_out = ir;
endmodule

// File: tb/sim_icyc_seq.sv
`timescale 1ns/100ps
module sim_icyc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reset_vec = 16'd0;
  logic        start = 1'b0, halt_req = 1'b0;
  logic        mem_req, mem_we, mem_ready, running, alu_en, reg_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, ir_out, pc_out;
  logic [15:0] st_data = 16'h5A5A;
  logic [2:0]  phase;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  icyc_seq u0 (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .start(start), .halt_req(halt_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .st_data(st_data), .ir_out(ir_out),
    .pc_out(pc_out), .phase(phase), .running(running), .alu_en(alu_en), .reg_we(reg_we)
  );

  // memory model: one ready pulse, lat cycles after the request
  logic [15:0] mem [64];
  logic        tb_ld = 1'b0;
  logic [5:0]  tb_la = '0;
  logic [15:0] tb_ld_d = '0;
  int          lat = 1;
  int          cnt = 0;
  logic        pend = 1'b0, pwe = 1'b0, rdy = 1'b0;
  logic [5:0]  pa = '0;
  logic [15:0] pwd = '0, rd = '0;
  assign mem_ready = rdy;
  assign mem_rdata = rd;

  always @(posedge clk) begin
    rdy <= 1'b0;
    if (tb_ld) mem[tb_la] <= tb_ld_d;
    if (mem_req) begin
      pend <= 1'b1; cnt <= lat; pa <= mem_addr[5:0]; pwe <= mem_we; pwd <= mem_wdata;
    end else if (pend) begin
      if (cnt <= 1) begin
        rdy <= 1'b1; pend <= 1'b0; rd <= mem[pa];
        if (pwe) mem[pa] <= pwd;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); tb_ld = 1'b1; tb_la = a; tb_ld_d = d;
    @(negedge clk); tb_ld = 1'b0;
  endtask

  typedef struct packed {
    logic [15:0] ins;
    logic [15:0] org;
    logic [15:0] ea;
    logic [15:0] npc;
    logic [5:0]  mask;
    logic [1:0]  lt;
    logic        rwe;
    logic        wr;
    logic        alu;
    logic        run;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{16'h1000, 16'd10, 16'd0,  16'd11, 6'h33, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 operate
    '{16'h2005, 16'd10, 16'd16, 16'd11, 6'h3F, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 load +5
    '{16'h21FC, 16'd20, 16'd17, 16'd21, 6'h3F, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 load -4
    '{16'h3007, 16'd12, 16'd20, 16'd13, 6'h37, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 store
    '{16'h4008, 16'd5,  16'd14, 16'd14, 6'h17, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 jump +8
    '{16'h41FD, 16'd30, 16'd28, 16'd28, 6'h17, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 jump -3
    '{16'hF000, 16'd3,  16'd0,  16'd4,  6'h13, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 halt
    '{16'h7000, 16'd40, 16'd0,  16'd41, 6'h33, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1}  // R12 other
  };

  // observed during one instruction
  logic [5:0]  seen;
  int          nreq, nrwe, nwr, nalu;
  logic [15:0] first_a, ldval, waddr, wdata, pc_at_req;

  task automatic watch_instr(output logic ok);
    logic left = 1'b0;
    seen = '0; nreq = 0; nrwe = 0; nwr = 0; nalu = 0;
    first_a = '1; pc_at_req = '1; ldval = '0; waddr = '0; wdata = '0;
    ok = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (left && phase == 3'd0) begin ok = 1'b1; break; end
      if (phase != 3'd0) left = 1'b1;
      seen[phase] = 1'b1;
      if (mem_req) begin
        if (nreq == 0) begin first_a = mem_addr; pc_at_req = pc_out; end
        nreq++;
        if (mem_we) begin nwr++; waddr = mem_addr; wdata = mem_wdata; end
      end
      if (reg_we) begin nrwe++; ldval = mem_wdata; end
      if (alu_en) nalu++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic ok;
    int q;
    rst = 1'b1;
    repeat (6) @(negedge clk);
    poke(v.org[5:0], v.ins);
    reset_vec = v.org; lat = int'(v.lt);
    repeat (2) @(negedge clk);
    chk(pc_out == v.org && running && phase == 3'd0 && !mem_req, "R1 reset state", {16'h0, pc_out}, {16'h0, v.org});
    rst = 1'b0;
    watch_instr(ok);
    chk(ok, "R3 instruction returns to fetch", ok, 1);
    chk(seen == v.mask, "R3 phases visited", seen, v.mask);
    chk(first_a == v.org && pc_at_req == v.org + 16'd1, "R2 fetch address and increment", first_a, v.org);
    chk(ir_out == v.ins, "R2 instruction register", ir_out, v.ins);
    chk(pc_out == v.npc, "R8 next program counter", pc_out, v.npc);
    q = 1 + int'(v.mask[3]) + int'(v.wr);
    chk(nreq == q, "R4 one request per memory phase", nreq, q);
    chk(nrwe == int'(v.rwe), "R5 R12 reg_we count", nrwe, v.rwe);
    chk(nalu == int'(v.alu), "R13 alu_en count", nalu, v.alu);
    chk(nwr == int'(v.wr), "R7 R12 memory write count", nwr, v.wr);
    if (v.ins[15:12] == 4'h2)
      chk(ldval == 16'hA000 + v.ea, "R6 loaded word at reg_we", ldval, 16'hA000 + v.ea);
    if (v.wr)
      chk(waddr == v.ea && wdata == st_data, "R7 store address and data", waddr, v.ea);
    chk(running == v.run, "R9 run bit after instruction", running, v.run);
    if (!v.run) begin
      q = 0;
      for (int c = 0; c < 8; c++) begin @(negedge clk); if (mem_req || reg_we || alu_en) q++; end
      chk(q == 0 && phase == 3'd0, "R9 quiet while halted", q, 0);
    end
  endtask

  initial begin : main
    logic ok;
    int q;
    logic [15:0] pc_hold;
    for (int i = 0; i < 64; i++) poke(i[5:0], 16'hA000 + 16'(i));
    for (int i = 0; i < 8; i++) run_vec(VT[i]);

    // R10: halt request during decode, then R11 restart
    rst = 1'b1;
    repeat (6) @(negedge clk);
    poke(6'd0, 16'h1000); poke(6'd1, 16'h1000); poke(6'd2, 16'h1000);
    reset_vec = 16'd0; lat = 2;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q = 0;
    for (int c = 0; c < 100 && phase != 3'd1; c++) @(negedge clk);
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    for (int c = 0; c < 100 && running; c++) begin
      if (reg_we) q++;
      @(negedge clk);
    end
    chk(!running, "R10 run bit cleared", running, 0);
    chk(q == 1, "R10 current instruction completed", q, 1);
    chk(pc_out == 16'd1, "R10 halted before next fetch", pc_out, 1);
    pc_hold = pc_out; q = 0;
    for (int c = 0; c < 10; c++) begin @(negedge clk); if (mem_req) q++; end
    chk(q == 0 && pc_out == pc_hold, "R10 no request while halted", q, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(running, "R11 start sets run bit", running, 1);
    watch_instr(ok);
    chk(ok && first_a == 16'd1, "R11 resumes at held counter", first_a, 1);
    chk(pc_out == 16'd2 && nrwe == 1, "R11 resumed instruction completes", pc_out, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule